// File: doc/BRIEF.md
# Serial Character Transmitter with Odd-Parity Slot

This block turns bytes into asynchronous serial frames on one output line. A byte enters through a valid/ready write port. The block sends a frame of eleven bit periods: a low start bit, then eight data slots least significant bit first, then two high stop bits. An external counter/timer sets the pace with a one-cycle bit-rate tick, and the line moves only on that tick.

If parity is requested when the byte is written, the eighth data slot does not carry data bit 7. It carries the odd parity of bits 6..0 instead, so the frame length stays the same. A busy flag covers the whole frame. A one-cycle interrupt request marks the end of each character.

Back-pressure works as follows. `in_ready` is high exactly when no frame is pending or in flight. A byte is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The parity choice is captured on that same edge. While `in_ready` is low, `in_valid` and `in_data` are ignored, and the source may hold or drop them.

Top module: `uart_char_tx`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `tx_line` is 1, `busy` is 0 and `irq` is 0. `in_ready` is 1 out of reset.
- R2: A write is accepted on a clock edge with `in_valid`=1 and `in_ready`=1. From the next cycle, `busy` is 1 and `in_ready` is 0 until the frame ends. `tx_line` stays 1 until the first tick after acceptance.
- R3: A frame is, in order: one start bit of 0, eight data slots with slot 0 first and slot k carrying `in_data[k]` for k = 0..6, then two stop bits of 1.
- R4: If `par_en` is 1 at acceptance, slot 7 carries the odd parity of `in_data[6:0]`. It is 1 when those seven bits hold an even number of ones. `in_data[7]` is discarded.
- R5: If `par_en` is 0 at acceptance, slot 7 carries `in_data[7]`.
- R6: `tx_line` changes only in the cycle that follows a cycle with `bit_tick`=1. The first such tick after acceptance starts the start bit, and each later tick starts the next bit, so every bit lasts one tick period.
- R7: The tick that ends the second stop bit (the 12th tick after acceptance) raises `irq` for exactly one cycle. `busy` drops in that same cycle. This happens for every character, with or without parity.
- R8: A write presented while `busy` is 1 is ignored. `in_ready` is 0, and the frame in progress and the frames that follow are unchanged.
- R9: A new write can be accepted in the same cycle that `irq` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle bit-rate pulse from the external timer |
| par_en | input | 1 | Odd parity in slot 7 when 1; sampled at acceptance |
| in_valid | input | 1 | Write data valid |
| in_ready | output | 1 | Write can be accepted (no frame pending) |
| in_data | input | 8 | Byte to send |
| tx_line | output | 1 | Serial output, idle high |
| busy | output | 1 | Frame pending or in flight |
| irq | output | 1 | One-cycle pulse at end of each character |

## Verification
Two events can fall in the same cycle: the completion pulse of one character and the acceptance of the next write. The bench provokes this by queueing a second byte while the first is still on the line. The driver then writes it on the first cycle that `in_ready` is back, and checks that `irq` is high in that cycle. The scoreboard then confirms that both frames arrive intact, with the second starting cleanly on the tick after acceptance. Ticks that land in the same cycle as an acceptance are also covered, because two tick spacings slide the phase between writes and ticks.

// File: rtl/uarttx_pkg.sv
package uarttx_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned STOP_W_DEF = 2;
endpackage

// File: rtl/uarttx_frame.sv
module uarttx_frame #(
  parameter int unsigned DATA_W = uarttx_pkg::DATA_W_DEF,
  parameter int unsigned STOP_W = uarttx_pkg::STOP_W_DEF,
  localparam int unsigned FRAME_W = 1 + DATA_W + STOP_W
) (
  input  logic [DATA_W-1:0]  data,
  input  logic               par_en,
  output logic [FRAME_W-1:0] frame
);
  logic top_slot;

  // odd parity: 1 when the lower bits hold an even number of ones
  assign top_slot = par_en ? ~^data[DATA_W-2:0] : data[DATA_W-1];

  assign frame[0] = 1'b0;
  genvar gi;
  generate
    for (gi = 0; gi < DATA_W - 1; gi++) begin : g_data
      assign frame[1+gi] = data[gi];
    end
    for (gi = 0; gi < STOP_W; gi++) begin : g_stop
      assign frame[1+DATA_W+gi] = 1'b1;
    end
  endgenerate
  assign frame[DATA_W] = top_slot;
endmodule

// File: rtl/uarttx_shift.sv
module uarttx_shift #(
  parameter int unsigned FRAME_W = 11,
  localparam int unsigned CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               tick,
  output logic               line,
  output logic               busy,
  output logic               done
);
  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '1;
      cnt  <= '0;
      busy <= 1'b0;
      line <= 1'b1;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        sreg <= frame_in;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy && tick) begin
        if (cnt == CNT_W'(FRAME_W)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          line <= sreg[0];
          sreg <= {1'b1, sreg[FRAME_W-1:1]};
          cnt  <= cnt + 1'b1;
        end
      end
    end
  end

  // R1: idle line is high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> line);
  // R6: the line only moves after a tick
  a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(line));
  // R7: completion pulse lasts one cycle
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: completion coincides with busy falling
  a_r7_irq_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/uart_char_tx.sv
module uart_char_tx #(
  parameter int unsigned DATA_W = uarttx_pkg::DATA_W_DEF,
  parameter int unsigned STOP_W = uarttx_pkg::STOP_W_DEF,
  localparam int unsigned FRAME_W = 1 + DATA_W + STOP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              par_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              tx_line,
  output logic              busy,
  output logic              irq
);
  logic [FRAME_W-1:0] frame;
  logic               accept;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  uarttx_frame #(.DATA_W(DATA_W), .STOP_W(STOP_W)) u_frame (
    .data   (in_data),
    .par_en (par_en),
    .frame  (frame)
  );

  uarttx_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .frame_in (frame),
    .tick     (bit_tick),
    .line     (tx_line),
    .busy     (busy),
    .done     (irq)
  );

  // R2: acceptance sets busy and leaves the line high until a tick
  a_r2_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && tx_line));
  // R8: a write while busy leaves busy asserted
  a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid && !bit_tick) |=> busy);
endmodule

// File: tb/sim_uart_char_tx.sv
module sim_uart_char_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic par_en = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, tx_line, busy, irq;

  int n_cmp = 0;
  int n_bad = 0;
  int tdiv = 4;
  logic [10:0] expq[$];

  always #5 clk = ~clk;

  uart_char_tx u0 (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .par_en(par_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .tx_line(tx_line), .busy(busy), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  function automatic logic [10:0] exp_frame(input logic [7:0] d, input bit p);
    logic [10:0] f;
    f[0] = 1'b0;
    for (int i = 0; i < 7; i++) f[1+i] = d[i];
    f[8] = p ? ((($countones(d[6:0])) % 2) == 0) : d[7];
    f[9] = 1'b1;
    f[10] = 1'b1;
    return f;
  endfunction

  task automatic send(input logic [7:0] d, input bit p, output bit saw_irq);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    saw_irq = irq;
    in_valid = 1'b1;
    in_data = d;
    par_en = p;
    expq.push_back(exp_frame(d, p));
    @(negedge clk);
    in_valid = 1'b0;
    par_en = !p;
    in_data = ~d;
  endtask

  // tick generator
  initial begin
    forever begin
      repeat (tdiv - 1) @(negedge clk);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  end

  // monitor / scoreboard
  initial begin
    bit prev = 1'b0;
    bit coll = 1'b0;
    int nb = 0;
    logic [10:0] got = '0;
    logic [10:0] e;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      #1;
      if (prev) begin
        if (!coll) begin
          if (tx_line == 1'b0) begin
            coll = 1'b1;
            got[0] = 1'b0;
            nb = 1;
            check(busy == 1'b1, "R2 busy during frame", 32'(busy), 32'd1);
          end
        end else if (nb < 11) begin
          got[nb] = tx_line;
          nb++;
        end else begin
          check(irq == 1'b1 && busy == 1'b0, "R7 irq at end of frame",
                32'({irq, busy}), 32'b10);
          if (expq.size() == 0) begin
            check(1'b0, "R8 unexpected extra frame", 32'(got), 32'h0);
          end else begin
            e = expq.pop_front();
            check(got == e, "R3/R4/R5 frame bits", 32'(got), 32'(e));
          end
          coll = 1'b0;
        end
      end else begin
        check(irq == 1'b0, "R7 irq only after tick", 32'(irq), 32'd0);
      end
      prev = bit_tick;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    report();
  end

  initial begin
    bit si;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(tx_line == 1'b1, "R1 reset line", 32'(tx_line), 32'd1);
    check(busy == 1'b0, "R1 reset busy", 32'(busy), 32'd0);
    check(irq == 1'b0, "R1 reset irq", 32'(irq), 32'd0);
    check(in_ready == 1'b1, "R1 reset ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    send(8'hA5, 1'b0, si);                 // R5
    @(negedge clk);
    check(busy && !in_ready, "R2 busy after accept", 32'({busy, in_ready}), 32'b10);
    check(tx_line == 1'b1 || bit_tick, "R2 line high before tick", 32'(tx_line), 32'd1);
    send(8'h3C, 1'b1, si);                 // R4, even ones -> 1
    send(8'h80, 1'b1, si);                 // R4, bit 7 discarded
    send(8'h7F, 1'b1, si);                 // R4, seven ones -> 0
    send(8'hFF, 1'b0, si);                 // R5
    send(8'h00, 1'b0, si);                 // R3

    // R8: write while busy is ignored
    send(8'h5A, 1'b0, si);
    repeat (6) @(negedge clk);
    check(in_ready == 1'b0, "R8 not ready while busy", 32'(in_ready), 32'd0);
    in_valid = 1'b1;
    in_data = 8'hC3;
    par_en = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;

    // R9: back-to-back with irq coinciding with acceptance
    send(8'h96, 1'b1, si);
    check(si == 1'b1, "R9 accept in irq cycle", 32'(si), 32'd1);
    send(8'h69, 1'b0, si);
    check(si == 1'b1, "R9 accept in irq cycle", 32'(si), 32'd1);

    // R6: different tick spacing
    tdiv = 7;
    send(8'h12, 1'b1, si);
    send(8'hED, 1'b0, si);

    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3 * 7) @(negedge clk);
    check(expq.size() == 0, "R3 all frames seen", 32'(expq.size()), 32'd0);
    check(tx_line == 1'b1 && !busy, "R1 idle after frames", 32'({tx_line, busy}), 32'b10);
    report();
  end
endmodule